// File: doc/BRIEF.md
# DRAM Address-Map Configuration Selector

This block picks which of sixteen fixed address-map configurations a memory scheduler should use, given the column and row address widths found on the attached DRAM, whether the data bus is fully populated (32 bits), and the bank/row/device ordering scheme that the platform asks for. Each table entry carries an ordering scheme and a (rows, columns) pair. The block walks the table from index 0 upward, one entry per clock, after a single-cycle start pulse. It reports the index of the first entry that satisfies the matching rule of the requested scheme, or raises a no-match flag if none does.

The matching rule depends on the scheme. Exact-order entries need both widths to be equal. Row-interleaved entries need equal columns and a table row count no larger than the detected one. Catch-all entries accept either equal columns, or the table's columns no larger than the detected columns together with equal rows. A narrow bus uses up one column address bit, so the detected column count is reduced by one before any comparison when the bus is not full width.

The result is registered and announced by a one-clock done pulse. It then stays put until the next scan completes, so the address translation logic downstream can use it without a handshake.

Top module: `amsel_top`

## Requirements
- R1: After reset, `done` is 0, `noMatch` is 0 and `cfgIndex` is 0.
- R2: Scheme code 0 (exact) selects among entries 0..10, whose (rows, cols) are 0:13/10, 1:14/10, 2:15/10, 3:16/10, 4:14/11, 5:15/11, 6:16/11, 7:13/9, 8:14/9, 9:15/9, 10:16/9, and matches only when both rows and effective columns are equal.
- R3: Scheme code 1 (rows-at-least) selects among entries 11:15/10, 12:14/11, 13:13/10, and matches when effective columns are equal and the entry's rows are less than or equal to the detected rows.
- R4: Scheme code 2 (catch-all) selects among entries 14:16/10, 15:16/9, and matches when effective columns are equal, or when the entry's columns are less than or equal to the effective columns and rows are equal.
- R5: Entries whose scheme differs from the requested one never match, and the lowest matching index is reported.
- R6: With `fullWidth` = 0 the effective column count is `colCount` - 1 (0 stays 0); with `fullWidth` = 1 it is `colCount`.
- R7: When no entry matches (including scheme code 3, which matches nothing), `done` is accompanied by `noMatch` = 1 and `cfgIndex` = 0.
- R8: For a start pulse sampled at clock edge E, a match on entry i raises `done` after edge E+i+1, and a miss raises it after edge E+16. `done` is high for exactly one clock.
- R9: `cfgIndex` and `noMatch` change only when `done` is raised and hold otherwise. Inputs are captured on the accepted start pulse, and a start pulse that arrives during a scan is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock pulse that begins a scan |
| scheme | input | 2 | Requested scheme: 0 exact, 1 rows-at-least, 2 catch-all, 3 none |
| rowCount | input | 5 | Detected row address bits |
| colCount | input | 4 | Detected column address bits (32-bit bus basis) |
| fullWidth | input | 1 | 1 when the data bus is the full 32 bits wide |
| done | output | 1 | One-clock completion pulse |
| noMatch | output | 1 | Set when the last scan found no entry |
| cfgIndex | output | 4 | Index of the selected configuration |

## Verification
The bench builds the block with its default parameters: sixteen entries, five-bit row and four-bit column widths. With these values every table entry is reachable and a scan can run all the way to the final index. The vector walk covers each scheme's hits at the first, middle and last entries of its group, misses where a rule boundary just fails (rows one short, columns one short), narrow-bus column shifts and the matchless scheme code. Each case also checks the done latency, which ties the index to its scan position. Directed cases cover a start pulse and changed inputs in the middle of a scan, and show that the result holds afterwards.

// File: rtl/amsel_pkg.sv
package amsel_pkg;

  localparam int ROW_W = 5;
  localparam int COL_W = 4;
  localparam int SCH_W = 2;
  localparam int DEF_ENTRIES = 16;

  typedef enum logic [SCH_W-1:0] {
    SCH_EXACT     = 2'd0,
    SCH_ROWS_MIN  = 2'd1,
    SCH_CATCH_ALL = 2'd2,
    SCH_NONE      = 2'd3
  } scheme_e;

  typedef struct packed {
    scheme_e          scheme;
    logic [ROW_W-1:0] rows;
    logic [COL_W-1:0] cols;
  } map_entry_t;

  typedef struct packed {
    logic load;
    logic advance;
    logic finishHit;
    logic finishMiss;
  } scan_strobe_t;

  function automatic map_entry_t mkEntry(input scheme_e s, input int r, input int c);
    map_entry_t e;
    e.scheme = s;
    e.rows   = ROW_W'(r);
    e.cols   = COL_W'(c);
    return e;
  endfunction

  // Fixed configuration table; order is the match priority.
  function automatic map_entry_t mapEntry(input int idx);
    case (idx)
      0:  return mkEntry(SCH_EXACT, 13, 10);
      1:  return mkEntry(SCH_EXACT, 14, 10);
      2:  return mkEntry(SCH_EXACT, 15, 10);
      3:  return mkEntry(SCH_EXACT, 16, 10);
      4:  return mkEntry(SCH_EXACT, 14, 11);
      5:  return mkEntry(SCH_EXACT, 15, 11);
      6:  return mkEntry(SCH_EXACT, 16, 11);
      7:  return mkEntry(SCH_EXACT, 13, 9);
      8:  return mkEntry(SCH_EXACT, 14, 9);
      9:  return mkEntry(SCH_EXACT, 15, 9);
      10: return mkEntry(SCH_EXACT, 16, 9);
      11: return mkEntry(SCH_ROWS_MIN, 15, 10);
      12: return mkEntry(SCH_ROWS_MIN, 14, 11);
      13: return mkEntry(SCH_ROWS_MIN, 13, 10);
      14: return mkEntry(SCH_CATCH_ALL, 16, 10);
      15: return mkEntry(SCH_CATCH_ALL, 16, 9);
      default: return mkEntry(SCH_NONE, 0, 0);
    endcase
  endfunction

endpackage

// File: rtl/amsel_rule.sv
module amsel_rule
  import amsel_pkg::*;
(
  input  map_entry_t       entry,
  input  scheme_e          reqScheme,
  input  logic [ROW_W-1:0] reqRows,
  input  logic [COL_W-1:0] reqCols,
  output logic             hit
);

  logic colsEq;
  logic colsLe;
  logic rowsEq;
  logic rowsLe;

  always_comb begin
    colsEq = (entry.cols == reqCols);
    colsLe = (entry.cols <= reqCols);
    rowsEq = (entry.rows == reqRows);
    rowsLe = (entry.rows <= reqRows);
    hit    = 1'b0;
    if (entry.scheme == reqScheme) begin
      case (reqScheme)
        SCH_EXACT:     hit = colsEq && rowsEq;
        SCH_ROWS_MIN:  hit = colsEq && rowsLe;
        SCH_CATCH_ALL: hit = colsEq || (colsLe && rowsEq);
        default:       hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/amsel_ctrl.sv
module amsel_ctrl
  import amsel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         entryMatch,
  input  logic         lastEntry,
  output scan_strobe_t strb,
  output logic         scanning
);

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;
  state_e state;
  state_e stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (entryMatch) begin
          strb.finishHit = 1'b1;
          stateNext      = ST_IDLE;
        end else if (lastEntry) begin
          strb.finishMiss = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strb.advance = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign scanning = (state == ST_SCAN);

  // R9: a start seen mid-scan never reloads the request
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    scanning |-> !strb.load);

  // R7: a miss is only declared on the last entry
  p_miss_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishMiss |-> (lastEntry && !entryMatch));

endmodule

// File: rtl/amsel_datapath.sv
module amsel_datapath
  import amsel_pkg::*;
#(
  parameter int NUM_ENTRIES = DEF_ENTRIES,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  scan_strobe_t     strb,
  input  logic [SCH_W-1:0] scheme,
  input  logic [ROW_W-1:0] rowCount,
  input  logic [COL_W-1:0] colCount,
  input  logic             fullWidth,
  output logic             entryMatch,
  output logic             lastEntry,
  output logic             done,
  output logic             noMatch,
  output logic [IDX_W-1:0] cfgIndex
);

  map_entry_t       tbl [NUM_ENTRIES];
  scheme_e          reqScheme;
  logic [ROW_W-1:0] reqRows;
  logic [COL_W-1:0] reqCols;
  logic [COL_W-1:0] effCols;
  logic [IDX_W-1:0] ptr;
  logic             doneQ;
  logic             errQ;
  logic [IDX_W-1:0] idxQ;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_tbl
    assign tbl[g] = mapEntry(g);
  end

  // R6: a narrow bus consumes one column bit
  always_comb begin
    if (!fullWidth && (colCount != '0)) effCols = colCount - COL_W'(1);
    else                                effCols = colCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqScheme <= SCH_NONE;
      reqRows   <= '0;
      reqCols   <= '0;
      ptr       <= '0;
    end else if (strb.load) begin
      reqScheme <= scheme_e'(scheme);
      reqRows   <= rowCount;
      reqCols   <= effCols;
      ptr       <= '0;
    end else if (strb.advance) begin
      ptr <= ptr + IDX_W'(1);
    end
  end

  amsel_rule rule_i (
    .entry     (tbl[ptr]),
    .reqScheme (reqScheme),
    .reqRows   (reqRows),
    .reqCols   (reqCols),
    .hit       (entryMatch)
  );

  assign lastEntry = (ptr == IDX_W'(NUM_ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      idxQ  <= '0;
    end else begin
      doneQ <= strb.finishHit || strb.finishMiss;
      if (strb.finishHit) begin
        errQ <= 1'b0;
        idxQ <= ptr;
      end else if (strb.finishMiss) begin
        errQ <= 1'b1;
        idxQ <= '0;
      end
    end
  end

  assign done     = doneQ;
  assign noMatch  = errQ;
  assign cfgIndex = idxQ;

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: the result holds between completions
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.finishHit || strb.finishMiss) |=> ($stable(idxQ) && $stable(errQ)));

  // R7: a miss reports index zero
  p_miss_index_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && errQ) |-> (idxQ == '0));

  // R5: a reported hit came from a matching entry in the previous cycle
  p_hit_matched_r5: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !errQ) |-> $past(entryMatch));

endmodule

// File: rtl/amsel_top.sv
module amsel_top
  import amsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] scheme,
  input  logic [4:0] rowCount,
  input  logic [3:0] colCount,
  input  logic       fullWidth,
  output logic       done,
  output logic       noMatch,
  output logic [3:0] cfgIndex
);

  scan_strobe_t strb;
  logic         entryMatch;
  logic         lastEntry;
  logic         scanning;

  amsel_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .entryMatch (entryMatch),
    .lastEntry  (lastEntry),
    .strb       (strb),
    .scanning   (scanning)
  );

  amsel_datapath #(.NUM_ENTRIES(DEF_ENTRIES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .scheme     (scheme),
    .rowCount   (rowCount),
    .colCount   (colCount),
    .fullWidth  (fullWidth),
    .entryMatch (entryMatch),
    .lastEntry  (lastEntry),
    .done       (done),
    .noMatch    (noMatch),
    .cfgIndex   (cfgIndex)
  );

  // R1: outputs come out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!done && !noMatch && (cfgIndex == 4'd0)));

endmodule

// File: tb/amsel_top_tb_top.sv
module amsel_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       start;
  logic [1:0] scheme;
  logic [4:0] rowCount;
  logic [3:0] colCount;
  logic       fullWidth;
  logic       done;
  logic       noMatch;
  logic [3:0] cfgIndex;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  amsel_top dut_i (.*);

  // {scheme, rows, cols, fullWidth, expNoMatch, expIdx}
  localparam int NV = 22;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 5'd13, 4'd10, 1'b1, 1'b0, 4'd0},   // R2 first entry
    {2'd0, 5'd16, 4'd11, 1'b1, 1'b0, 4'd6},   // R2
    {2'd0, 5'd15, 4'd9,  1'b1, 1'b0, 4'd9},   // R2
    {2'd0, 5'd16, 4'd9,  1'b1, 1'b0, 4'd10},  // R2 last of group
    {2'd0, 5'd12, 4'd10, 1'b1, 1'b1, 4'd0},   // R2 rows too small
    {2'd0, 5'd14, 4'd11, 1'b0, 1'b0, 4'd1},   // R6 narrow bus
    {2'd0, 5'd13, 4'd11, 1'b0, 1'b0, 4'd0},   // R6 narrow bus
    {2'd1, 5'd15, 4'd10, 1'b1, 1'b0, 4'd11},  // R3 rows equal
    {2'd1, 5'd16, 4'd10, 1'b1, 1'b0, 4'd11},  // R3 rows exceed
    {2'd1, 5'd14, 4'd10, 1'b1, 1'b0, 4'd13},  // R3 skip 11, R5
    {2'd1, 5'd14, 4'd11, 1'b1, 1'b0, 4'd12},  // R3
    {2'd1, 5'd13, 4'd11, 1'b1, 1'b1, 4'd0},   // R3 rows one short
    {2'd1, 5'd12, 4'd10, 1'b1, 1'b1, 4'd0},   // R3 miss
    {2'd2, 5'd12, 4'd10, 1'b1, 1'b0, 4'd14},  // R4 cols equal
    {2'd2, 5'd12, 4'd9,  1'b1, 1'b0, 4'd15},  // R4 cols equal later
    {2'd2, 5'd16, 4'd11, 1'b1, 1'b0, 4'd14},  // R4 excess cols, rows equal
    {2'd2, 5'd15, 4'd11, 1'b1, 1'b1, 4'd0},   // R4 miss
    {2'd2, 5'd14, 4'd9,  1'b0, 1'b1, 4'd0},   // R4 R6 cols one short
    {2'd2, 5'd16, 4'd12, 1'b0, 1'b0, 4'd14},  // R4 R6
    {2'd3, 5'd13, 4'd10, 1'b1, 1'b1, 4'd0},   // R7 matchless scheme
    {2'd0, 5'd16, 4'd10, 1'b1, 1'b0, 4'd3},   // R5 exact entry wins over 14
    {2'd0, 5'd13, 4'd9,  1'b1, 1'b0, 4'd7}    // R2
  };

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Start pulse, then count negedges until done; returns latency.
  task automatic runScan(input logic [1:0] s, input logic [4:0] r, input logic [3:0] c,
                         input logic f, output int lat);
    @(negedge clk);
    scheme = s; rowCount = r; colCount = c; fullWidth = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    rstN = 1'b0; start = 1'b0; scheme = '0; rowCount = '0; colCount = '0; fullWidth = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done", done == 1'b0, done, 0);
    check("R1 noMatch", noMatch == 1'b0, noMatch, 0);
    check("R1 cfgIndex", cfgIndex == 4'd0, cfgIndex, 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [16:0] e;
      int expLat;
      e = VEC[v];
      runScan(e[16:15], e[14:10], e[9:6], e[5], lat);
      expLat = e[4] ? 16 : int'(e[3:0]) + 1;
      check($sformatf("R2-group vector %0d noMatch R7", v), noMatch == e[4], noMatch, e[4]);
      check($sformatf("vector %0d cfgIndex R5", v), cfgIndex == e[3:0], cfgIndex, e[3:0]);
      check($sformatf("vector %0d latency R8", v), lat == expLat, lat, expLat);
      @(negedge clk);
      check($sformatf("vector %0d done pulse R8", v), done == 1'b0, done, 0);
    end

    // R9: start and changed inputs in mid-scan are ignored
    @(negedge clk);
    scheme = 2'd0; rowCount = 5'd16; colCount = 4'd9; fullWidth = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rowCount = 5'd13; colCount = 4'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R9 mid-scan start latency", lat == 11, lat, 11);
    check("R9 mid-scan start index", cfgIndex == 4'd10, cfgIndex, 10);

    // R9: result holds with inputs moving and no start
    scheme = 2'd3; colCount = 4'd0;
    repeat (6) @(negedge clk);
    check("R9 hold index", cfgIndex == 4'd10, cfgIndex, 10);
    check("R9 hold noMatch", noMatch == 1'b0, noMatch, 0);
    check("R9 no spurious done", done == 1'b0, done, 0);

    // R7 then R9: miss flag holds
    runScan(2'd3, 5'd16, 4'd10, 1'b1, lat);
    check("R7 miss latency", lat == 16, lat, 16);
    repeat (4) @(negedge clk);
    check("R9 noMatch held", noMatch == 1'b1, noMatch, 1);

    // R6: zero columns on a narrow bus stay zero (no match on catch-all)
    runScan(2'd2, 5'd12, 4'd0, 1'b0, lat);
    check("R6 zero cols", noMatch == 1'b1, noMatch, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule